// File: doc/BRIEF.md
# Receive FIFO with Line Status

This block stores characters delivered by a serial receiver and presents them, together with a byte-wide line status view, to a CPU register port. Every stored character keeps its own parity, framing and break tags. A tag shows up in the status view only when its character reaches the head of the queue. A summary bit reports, in queued mode, that at least one tagged character is still stored or still unacknowledged.

Characters enter on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and every offered character is either stored, dropped (queued mode, full) or written over the held one (single-register mode, occupied). In both of the last two cases the block flags an overrun. Characters leave on a second valid/ready stream. `out_valid` means a character is held. The CPU's data-read strobe is `out_ready`, and a character is consumed in any cycle where both are high. The status-read strobe, the mode select and the interrupt enable are plain level inputs.

Top module: `rx_line_fifo`

## Requirements
- R1: `in_ready` is always 1. `out_valid` and `lsr[0]` are 1 exactly when at least one character is stored. `out_data` is the oldest stored character. A character is removed in a cycle where `out_valid` and `out_ready` are both high.
- R2: With `fifo_en`=1 the queue holds up to DEPTH (16) characters. A write is stored when fewer than DEPTH are held or a removal happens in the same cycle. Otherwise the write is discarded and the overrun flag is raised.
- R3: With `fifo_en`=0 the capacity is one. A write that arrives while a character is held and not being removed replaces that character and its tags, and raises overrun.
- R4: `lsr[1]` (overrun) becomes 1 in the cycle after a discarded or replacing write, or after `ovr_evt`. It becomes 0 in the cycle after a status read (`lsr_rd`) in which no new overrun occurs.
- R5: `lsr[2]` (parity), `lsr[3]` (framing) and `lsr[4]` (break) show the tags of the head character while it is held. Each also has a sticky copy that captures the head tags when the head is removed. A status read clears the copy, but a removal in the same cycle captures the removed tags again.
- R6: `lsr[7]` is 1 in queued mode while any stored character carries a tag or any sticky copy of R5 is set. It is always 0 when `fifo_en`=0.
- R7: `rls_irq` equals `rls_ie` AND the OR of `lsr[4:1]`.
- R8: `lsr[6:5]` always read 0.
- R9: Tags of a character that is stored but not at the head do not appear in `lsr[4:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: queued mode, 0: single-register mode |
| in_valid | input | 1 | Received character offered |
| in_ready | output | 1 | Always 1 |
| in_data | input | 8 | Received character |
| in_pe | input | 1 | Parity error tag |
| in_fe | input | 1 | Framing error tag |
| in_bi | input | 1 | Break tag |
| ovr_evt | input | 1 | External overrun event |
| out_valid | output | 1 | A character is held |
| out_ready | input | 1 | CPU data-read strobe |
| out_data | output | 8 | Head character |
| lsr_rd | input | 1 | CPU status-read strobe |
| lsr | output | 8 | Line status view |
| rls_ie | input | 1 | Line status interrupt enable |
| rls_irq | output | 1 | Line status interrupt request |

## Verification
The assertions assume that `fifo_en` changes only while the block holds no character. Otherwise a switch to single-register mode could leave more characters stored than the capacity allows. The bench drains the queue and clears status before every mode change. Apart from that, stimulus is free: writes, reads, status reads and external overrun events can coincide in any combination, including writes to a full queue alongside a removal.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned TAG_W  = 3;

  typedef struct packed {
    logic              bi;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic       ovwr,
  input  rxq_entry_t wdata,
  output rxq_entry_t head,
  output logic [CW-1:0] count
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  rxq_entry_t    slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if ((push && wr_ptr == PW'(i)) || (ovwr && rd_ptr == PW'(i)))
          slot[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign head = slot[rd_ptr];

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop) |-> !push);
  p_no_underflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pop);
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          ovwr,
  input  logic          new_err,
  input  logic          head_err,
  input  logic [CW-1:0] occ,
  output logic          err_any
);
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (push && new_err) cnt_n = cnt_n + CW'(1);
    if (pop && head_err) cnt_n = cnt_n - CW'(1);
    if (ovwr) begin
      if (new_err)  cnt_n = cnt_n + CW'(1);
      if (head_err) cnt_n = cnt_n - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign err_any = (cnt != '0);

  p_errcnt_le_occ_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= occ);
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             lsr_rd,
  input  logic             pop,
  input  logic             ovr_set,
  input  logic             head_valid,
  input  logic [TAG_W-1:0] head_tags,
  input  logic             err_any,
  input  logic             rls_ie,
  output logic [7:0]       lsr,
  output logic             rls_irq
);
  logic             ovr_q;
  logic [TAG_W-1:0] stk_q;
  logic [TAG_W-1:0] tags_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      stk_q <= '0;
    end else begin
      ovr_q <= (ovr_q & ~lsr_rd) | ovr_set;
      stk_q <= (lsr_rd ? '0 : stk_q) | (pop ? head_tags : '0);
    end
  end

  assign tags_vis = stk_q | (head_valid ? head_tags : '0);
  assign lsr      = {fifo_en & (err_any | (|stk_q)), 2'b00, tags_vis, ovr_q, head_valid};
  assign rls_irq  = rls_ie & (|lsr[4:1]);

  p_ovr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> lsr[1]);
  p_ovr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_set) |=> !lsr[1]);
  p_sticky_on_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (|head_tags)) |=> (|lsr[4:2]));
endmodule

// File: rtl/rx_line_fifo.sv
module rx_line_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_en,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_pe,
  input  logic        in_fe,
  input  logic        in_bi,
  input  logic        ovr_evt,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  input  logic        lsr_rd,
  output logic [7:0]  lsr,
  input  logic        rls_ie,
  output logic        rls_irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rxq_entry_t    wdata, head;
  logic [CW-1:0] count;
  logic          full, pop, accept, drop, ovwr, ovr_set, err_any;

  assign wdata     = '{bi: in_bi, fe: in_fe, pe: in_pe, data: in_data};
  assign out_valid = (count != '0);
  assign in_ready  = 1'b1;
  assign out_data  = head.data;
  assign pop       = out_valid & out_ready;
  assign full      = fifo_en ? (count >= CW'(DEPTH)) : out_valid;
  assign accept    = in_valid & (~full | pop);
  assign drop      = in_valid & full & ~pop;
  assign ovwr      = drop & ~fifo_en;
  assign ovr_set   = ovr_evt | drop;

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(pop), .ovwr(ovwr),
    .wdata(wdata), .head(head), .count(count)
  );

  rxq_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(pop), .ovwr(ovwr),
    .new_err(in_pe | in_fe | in_bi), .head_err(head.pe | head.fe | head.bi),
    .occ(count), .err_any(err_any)
  );

  rxq_status u_status (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lsr_rd(lsr_rd), .pop(pop),
    .ovr_set(ovr_set), .head_valid(out_valid),
    .head_tags({head.bi, head.fe, head.pe}), .err_any(err_any),
    .rls_ie(rls_ie), .lsr(lsr), .rls_irq(rls_irq)
  );

  p_dr_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_single_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (count <= CW'(1)));
  p_drop_holds_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && drop) |=> $stable(count));
endmodule

// File: tb/rx_line_fifo_tb.sv
`timescale 1ns/1ps
module rx_line_fifo_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1, in_valid = 1'b0, in_pe = 1'b0, in_fe = 1'b0, in_bi = 1'b0;
  logic ovr_evt = 1'b0, out_ready = 1'b0, lsr_rd = 1'b0, rls_ie = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, rls_irq;
  logic [7:0] out_data, lsr;

  int n_chk = 0, n_fail = 0;

  logic [10:0] mq[$];
  logic        m_ovr;
  logic [2:0]  m_stk;

  always #2.5 clk = ~clk;

  rx_line_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_pe(in_pe), .in_fe(in_fe),
    .in_bi(in_bi), .ovr_evt(ovr_evt), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .lsr_rd(lsr_rd), .lsr(lsr),
    .rls_ie(rls_ie), .rls_irq(rls_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_lsr();
    logic [2:0] vis;
    logic anyq;
    anyq = 1'b0;
    foreach (mq[i]) if (|mq[i][10:8]) anyq = 1'b1;
    vis = m_stk | ((mq.size() > 0) ? mq[0][10:8] : 3'b000);
    return {fifo_en & (anyq | (|m_stk)), 2'b00, vis, m_ovr, (mq.size() > 0)};
  endfunction

  task automatic compare_all();
    logic [7:0] e;
    e = exp_lsr();
    chk("R1 in_ready", in_ready, 1'b1);
    chk("R1 out_valid", out_valid, mq.size() > 0);
    chk("R1 lsr0", lsr[0], e[0]);
    if (mq.size() > 0) chk("R1 out_data", out_data, mq[0][7:0]);
    chk("R4 lsr1", lsr[1], e[1]);
    chk("R5 lsr4:2", lsr[4:2], e[4:2]);
    chk("R8 lsr6:5", lsr[6:5], 2'b00);
    chk("R6 lsr7", lsr[7], e[7]);
    chk("R7 irq", rls_irq, rls_ie & (|e[4:1]));
  endtask

  task automatic model_update();
    logic pop, acc, drp;
    int cap;
    cap = fifo_en ? DEPTH : 1;
    pop = out_ready && (mq.size() > 0);
    acc = in_valid && ((mq.size() < cap) || pop);
    drp = in_valid && !acc;
    m_stk = (lsr_rd ? 3'b000 : m_stk) | (pop ? mq[0][10:8] : 3'b000);
    m_ovr = (lsr_rd ? 1'b0 : m_ovr) | ovr_evt | drp;
    if (pop) void'(mq.pop_front());
    if (acc) mq.push_back({in_bi, in_fe, in_pe, in_data});
    else if (drp && !fifo_en) mq[0] = {in_bi, in_fe, in_pe, in_data};
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic [2:0] t,
                      input logic oe, input logic rdy, input logic srd);
    @(negedge clk);
    in_valid = v; in_data = d; {in_bi, in_fe, in_pe} = t;
    ovr_evt = oe; out_ready = rdy; lsr_rd = srd;
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    #1;
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pops;
    logic [7:0] last;
    mq.delete(); m_ovr = 1'b0; m_stk = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 reset out_valid", out_valid, 1'b0);
    chk("R4 reset lsr", lsr, 8'h00);
    chk("R7 reset irq", rls_irq, 1'b0);

    // R9: tag of a non-head entry stays hidden
    fifo_en = 1'b1; rls_ie = 1'b1;
    step(1'b1, 8'h11, 3'b000, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h22, 3'b001, 1'b0, 1'b0, 1'b0);
    chk("R9 hidden tag", lsr[4:2], 3'b000);
    chk("R6 summary", lsr[7], 1'b1);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
    chk("R9 head tag shown", lsr[4:2], 3'b001);
    chk("R7 irq on pe", rls_irq, 1'b1);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
    chk("R5 sticky after pop", lsr[4:2], 3'b001);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 1'b1);
    chk("R5 cleared by read", lsr[4:2], 3'b000);
    chk("R6 cleared by read", lsr[7], 1'b0);

    // R2: fill past capacity
    for (int i = 0; i <= DEPTH; i++) step(1'b1, 8'(i), 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R2 overrun on full", lsr[1], 1'b1);
    pops = 0; last = 8'h00;
    while (out_valid) begin
      last = out_data;
      step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 1'b0);
      pops++;
    end
    chk("R2 stored count", pops, DEPTH);
    chk("R2 last stored", last, 8'(DEPTH - 1));
    drain();

    // R3: single-register overwrite
    fifo_en = 1'b0;
    step(1'b1, 8'hA5, 3'b100, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h5A, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R3 overwrite data", out_data, 8'h5A);
    chk("R3 overwrite tags", lsr[4:2], 3'b010);
    chk("R3 overrun", lsr[1], 1'b1);
    chk("R6 off in single mode", lsr[7], 1'b0);
    drain();

    // random traffic with mode changes on empty
    for (int blk = 0; blk < 8; blk++) begin
      fifo_en = blk[0];
      for (int c = 0; c < 600; c++) begin
        logic [31:0] r;
        r = $urandom;
        rls_ie = r[20];
        step(r[2:0] < 3'd4, r[15:8],
             (r[18:16] == 3'd7) ? 3'b000 : ((r[19] && r[5]) ? r[18:16] : 3'b000),
             r[28:24] == 5'd0, (blk[1] ? r[4:3] == 2'b00 : r[4:3] != 2'b00),
             r[7:6] == 2'b00);
      end
      drain();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule